// File: doc/BRIEF.md
# Interrupt Pending and Transfer Dispatch

This block collects interrupt requests from a set of sources and holds each one in a pending bit until it is serviced. A mask register gates which pending sources may be offered. Whenever the global enable is high and at least one pending, unmasked source exists, a small two-state controller latches the highest-numbered such source and offers it on the vector outputs until it is acknowledged or withdrawn.

Each source is steered by its own select bit. When the bit is clear, the source is served by an ordinary vectored routine. When it is set, the source is served by a counted transfer engine. In that case every acknowledge decrements the source's transfer count. Once the count is used up, hardware returns the source to vectored service and sets a service bit, which raises an end-of-transfer request.

Software reaches the registers through a simple write/read port. The controller has two states:
- ST_IDLE: nothing is offered. It moves to ST_OFFER when the enable is high and a candidate exists; the winner is latched on that transition.
- ST_OFFER: the latched vector is presented. It returns to ST_IDLE on acknowledge, or on withdrawal when the enable drops or the offered source stops being pending and unmasked.

Top module: `intr_dispatch`

## Requirements
- R1: After reset, the mask, pending, select and service registers and every transfer count read zero, vec_valid is low and eot_req is low.
- R2: A high req bit sets the matching pending bit at the next clock edge, whatever the mask or gie values; pending bits can be read at address 1 and cannot be written.
- R3: vec_valid rises only in the cycle after an edge at which gie was high and the pending-and-mask set was non-empty.
- R4: The source offered is the highest-numbered bit of pending AND mask at the moment the offer starts.
- R5: vec_xfer shows the select bit of the offered source. The register addresses are: 0 mask, 1 pending, 2 select, 3 service. When the top address bit is set, the address reaches the transfer count of the source given by the low address bits.
- R6: An acknowledge while offering clears the offered source's pending bit and returns the controller to idle. A request for the same source in the same cycle leaves the bit set.
- R7: An acknowledge of a source whose select bit is set decrements its transfer count, saturating at zero. If the result is zero, that source's select bit is cleared and its service bit is set at the same edge.
- R8: eot_req is high exactly while any service bit is set; software writing the service register clears the bits it writes as zero.
- R9: An offer is withdrawn (vec_valid low after the next edge) when gie is low or the offered source is no longer both pending and unmasked, provided no acknowledge is given.
- R10: An acknowledge given while nothing is offered changes no pending bit and no transfer count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global dispatch enable |
| req | input | NSRC | Per-source request strobes |
| ack | input | 1 | Offered vector is taken |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NSRC)+1 | Register address |
| reg_wdata | input | NSRC | Register write data |
| reg_rdata | output | NSRC | Register read data (combinational) |
| vec_valid | output | 1 | A vector is being offered |
| vec_id | output | $clog2(NSRC) | Offered source number |
| vec_xfer | output | 1 | Offered source uses the transfer engine |
| eot_req | output | 1 | End-of-transfer request |

## Verification
The assertions check several properties on every cycle: that requests always reach their pending bits, that an acknowledge clears the offered bit unless the same source requests again, that the priority pick is the top enabled bit, that an exhausted count retires its source, and that an idle acknowledge leaves pending untouched. Some behaviour only shows up over whole sequences, and the bench scenarios cover it: the drain order across many mask and request patterns, the count stepping down to retirement, the switch of vec_xfer once the source has retired, withdrawal when the mask changes, and service clearing by software.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } disp_state_e;

    localparam int RA_MASK = 0;
    localparam int RA_PEND = 1;
    localparam int RA_SEL  = 2;
    localparam int RA_SERV = 3;

endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/intr_xfer_count.sv
module intr_xfer_count #(
    parameter int NSRC = 16,
    parameter int CNTW = 8,
    localparam int IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [CNTW-1:0] wr_data,
    input  logic            dec_en,
    input  logic [IDXW-1:0] dec_idx,
    input  logic [IDXW-1:0] rd_idx,
    output logic [CNTW-1:0] rd_data,
    output logic            dec_zero
);

    logic [CNTW-1:0] cnt_all [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_cnt
        logic [CNTW-1:0] c_q;
        logic            wr_hit;
        logic            dec_hit;

        assign wr_hit  = wr_en  && (wr_idx  == IDXW'(g));
        assign dec_hit = dec_en && (dec_idx == IDXW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_q <= '0;
            end else if (wr_hit) begin
                c_q <= wr_data;
            end else if (dec_hit && (c_q != '0)) begin
                c_q <= c_q - CNTW'(1);
            end
        end

        assign cnt_all[g] = c_q;
    end

    assign rd_data  = cnt_all[rd_idx];
    assign dec_zero = (cnt_all[dec_idx] <= CNTW'(1));

    // R7: an uncontested decrement of a non-zero count lowers it by one
    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(wr_en && wr_idx == dec_idx) && cnt_all[dec_idx] != '0)
        |=> (cnt_all[$past(dec_idx)] == $past(cnt_all[dec_idx]) - CNTW'(1)));

endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
    import intr_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int CNTW = 8,
    localparam int IDXW = $clog2(NSRC),
    localparam int AW   = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gie,
    input  logic [NSRC-1:0] req,
    input  logic            ack,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            vec_valid,
    output logic [IDXW-1:0] vec_id,
    output logic            vec_xfer,
    output logic            eot_req
);

    disp_state_e     state_q, state_n;
    logic [IDXW-1:0] vec_q;
    logic [NSRC-1:0] mask_q, pend_q, sel_q, serv_q;
    logic [NSRC-1:0] pend_n, sel_n, serv_n, cand, vec_oh;
    logic            win_any, live, take, xfer_take, exhaust, dec_zero;
    logic [IDXW-1:0] win_idx, low;
    logic            is_cnt, wr_mask, wr_sel, wr_serv, wr_cnt;
    logic [CNTW-1:0] cnt_rd;

    assign cand   = pend_q & mask_q;
    assign vec_oh = NSRC'(1) << vec_q;
    assign is_cnt = reg_addr[AW-1];
    assign low    = reg_addr[IDXW-1:0];

    assign wr_mask = reg_we && !is_cnt && (low == IDXW'(RA_MASK));
    assign wr_sel  = reg_we && !is_cnt && (low == IDXW'(RA_SEL));
    assign wr_serv = reg_we && !is_cnt && (low == IDXW'(RA_SERV));
    assign wr_cnt  = reg_we && is_cnt;

    intr_prio_pick #(.N(NSRC)) u_pick (
        .cand (cand),
        .any  (win_any),
        .idx  (win_idx)
    );

    assign live      = gie && pend_q[vec_q] && mask_q[vec_q];
    assign take      = (state_q == ST_OFFER) && ack;
    assign xfer_take = take && sel_q[vec_q];
    assign exhaust   = xfer_take && dec_zero;

    intr_xfer_count #(.NSRC(NSRC), .CNTW(CNTW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cnt),
        .wr_idx   (low),
        .wr_data  (reg_wdata[CNTW-1:0]),
        .dec_en   (xfer_take),
        .dec_idx  (vec_q),
        .rd_idx   (low),
        .rd_data  (cnt_rd),
        .dec_zero (dec_zero)
    );

    // Next-state selection
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (gie && win_any) state_n = ST_OFFER;
            ST_OFFER: if (ack || !live)   state_n = ST_IDLE;
        endcase
    end

    // State register and latched vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && state_n == ST_OFFER) vec_q <= win_idx;
        end
    end

    // Outputs
    always_comb begin
        vec_valid = (state_q == ST_OFFER);
        vec_id    = vec_q;
        vec_xfer  = sel_q[vec_q];
        eot_req   = |serv_q;
    end

    // Register next values
    always_comb begin
        pend_n = (pend_q & ~(take ? vec_oh : '0)) | req;
        sel_n  = wr_sel  ? reg_wdata : sel_q;
        serv_n = wr_serv ? reg_wdata : serv_q;
        if (exhaust) begin
            sel_n[vec_q]  = 1'b0;
            serv_n[vec_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
            sel_q  <= '0;
            serv_q <= '0;
        end else begin
            if (wr_mask) mask_q <= reg_wdata;
            pend_q <= pend_n;
            sel_q  <= sel_n;
            serv_q <= serv_n;
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (is_cnt) begin
            reg_rdata = NSRC'(cnt_rd);
        end else begin
            unique case (low)
                IDXW'(RA_MASK): reg_rdata = mask_q;
                IDXW'(RA_PEND): reg_rdata = pend_q;
                IDXW'(RA_SEL):  reg_rdata = sel_q;
                IDXW'(RA_SERV): reg_rdata = serv_q;
                default:        reg_rdata = '0;
            endcase
        end
    end

    a_r2_req_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |=> ((pend_q & $past(req)) == $past(req)));

    a_r3_offer_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(gie));

    a_r4_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        win_any |-> ((cand >> win_idx) == NSRC'(1)));

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req[vec_q]) |=> (!pend_q[$past(vec_q)] && !vec_valid));

    a_r7_retire: assert property (@(posedge clk) disable iff (!rst_n)
        exhaust |=> (serv_q[$past(vec_q)] && !sel_q[$past(vec_q)]));

    a_r9_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !gie && !ack) |=> !vec_valid);

    a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ack && !(|req)) |=> (pend_q == $past(pend_q)));

endmodule

// File: tb/sim_intr_dispatch.sv
module sim_intr_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int CNTW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gie = 1'b1;
    logic [15:0] req = '0;
    logic        ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        vec_valid;
    logic [3:0]  vec_id;
    logic        vec_xfer;
    logic        eot_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_dispatch #(.NSRC(NSRC), .CNTW(CNTW)) u0 (
        .clk(clk), .rst_n(rst_n), .gie(gie), .req(req), .ack(ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_id(vec_id),
        .vec_xfer(vec_xfer), .eot_req(eot_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_req(input logic [15:0] v);
        req = v;
        tick();
        req = '0;
    endtask

    function automatic int hi(input logic [15:0] v);
        int r = 0;
        for (int i = 0; i < 16; i++) if (v[i]) r = i;
        return r;
    endfunction

    // Entered with an offer already running; acknowledges in expected order
    task automatic drain(input logic [15:0] set, input string tag);
        logic [15:0] rem = set;
        while (rem != '0) begin
            int e = hi(rem);
            chk({tag, " R4 valid"}, 32'(vec_valid), 32'd1);
            chk({tag, " R4 id"}, 32'(vec_id), 32'(e));
            ack = 1'b1;
            tick();
            ack = 1'b0;
            rem[e] = 1'b0;
            tick();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(5'(a), d);
            chk("R1 reg", 32'(d), 32'd0);
        end
        tick();
        rd(5'd21, d);
        chk("R1 count", 32'(d), 32'd0);
        chk("R1 vec_valid", 32'(vec_valid), 32'd0);
        chk("R1 eot_req", 32'(eot_req), 32'd0);

        // R2/R4 sweep over mask and request patterns
        for (int t = 0; t < 30; t++) begin
            logic [15:0] m = 16'(t * 16'h2F1D) ^ 16'h5A3C;
            logic [15:0] p = 16'(t * 16'h9E37 + 16'h0101);
            if (p == '0) p = 16'h0001;
            wr(5'd0, m);
            pulse_req(p);
            tick();
            drain(p & m, "sweep enabled");
            chk("R3 no offer when none enabled", 32'(vec_valid), 32'd0);
            rd(5'd1, d);
            chk("R2 masked stay pending", 32'(d), 32'(p & ~m));
            wr(5'd0, 16'hFFFF);
            tick();
            drain(p & ~m, "sweep rest");
            chk("R3 idle after drain", 32'(vec_valid), 32'd0);
            rd(5'd1, d);
            chk("R6 pending empty", 32'(d), 32'd0);
        end

        // R3 gie low suppresses dispatch, not latching; R9 withdrawal
        gie = 1'b0;
        wr(5'd0, 16'h0F00);
        pulse_req(16'h0300);
        tick(); tick();
        chk("R3 gie low no offer", 32'(vec_valid), 32'd0);
        rd(5'd1, d);
        chk("R2 latch under gie low", 32'(d), 32'h0300);
        gie = 1'b1;
        tick();
        chk("R3 offer after gie", 32'(vec_valid), 32'd1);
        chk("R4 id 9", 32'(vec_id), 32'd9);
        gie = 1'b0;
        tick();
        chk("R9 withdraw on gie", 32'(vec_valid), 32'd0);
        gie = 1'b1;
        tick();
        chk("R9 reoffer", 32'(vec_id), 32'd9);
        wr(5'd0, 16'h0100);
        tick();
        chk("R9 withdraw on mask", 32'(vec_valid), 32'd0);
        tick();
        chk("R9 offer 8", 32'(vec_id), 32'd8);
        wr(5'd0, 16'h0300);
        ack = 1'b1; tick(); ack = 1'b0;
        tick();
        chk("R4 then 9", 32'(vec_id), 32'd9);
        ack = 1'b1; tick(); ack = 1'b0;
        tick();

        // R6 same-cycle request and acknowledge
        wr(5'd0, 16'hFFFF);
        pulse_req(16'h0008);
        tick();
        chk("R6 offer 3", 32'(vec_id), 32'd3);
        ack = 1'b1; req = 16'h0008;
        tick();
        ack = 1'b0; req = '0;
        rd(5'd1, d);
        chk("R6 req wins over ack", 32'(d), 32'h0008);
        tick();
        chk("R6 reoffer 3", 32'(vec_id), 32'd3);
        ack = 1'b1; tick(); ack = 1'b0;
        tick();

        // R10 ack while idle; R5/R7/R8 transfer path
        wr(5'd2, 16'h0010);
        wr(5'd20, 16'h0002);
        wr(5'd0, 16'h0000);
        pulse_req(16'h0010);
        ack = 1'b1; tick(); ack = 1'b0;
        rd(5'd1, d);
        chk("R10 pending kept", 32'(d), 32'h0010);
        rd(5'd20, d);
        chk("R10 count kept", 32'(d), 32'd2);
        chk("R10 no offer", 32'(vec_valid), 32'd0);
        wr(5'd0, 16'hFFFF);
        tick();
        chk("R5 offer 4", 32'(vec_id), 32'd4);
        chk("R5 xfer path", 32'(vec_xfer), 32'd1);
        ack = 1'b1; tick(); ack = 1'b0;
        rd(5'd20, d);
        chk("R7 count 1", 32'(d), 32'd1);
        rd(5'd2, d);
        chk("R7 select kept", 32'(d), 32'h0010);
        chk("R8 no eot yet", 32'(eot_req), 32'd0);
        pulse_req(16'h0010);
        tick();
        chk("R5 xfer again", 32'(vec_xfer), 32'd1);
        ack = 1'b1; tick(); ack = 1'b0;
        rd(5'd20, d);
        chk("R7 count 0", 32'(d), 32'd0);
        rd(5'd2, d);
        chk("R7 select cleared", 32'(d), 32'd0);
        rd(5'd3, d);
        chk("R7 service set", 32'(d), 32'h0010);
        chk("R8 eot high", 32'(eot_req), 32'd1);
        pulse_req(16'h0010);
        tick();
        chk("R5 vectored after retire", 32'(vec_xfer), 32'd0);
        ack = 1'b1; tick(); ack = 1'b0;
        wr(5'd3, 16'h0000);
        chk("R8 eot cleared", 32'(eot_req), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule